// File: doc/BRIEF.md
# Iterative Integer Square Root Unit

This block returns the integer square root of an 8-bit unsigned operand that is a perfect square. It does not use a closed-form or bit-serial method. It makes a coarse first estimate from the operand, then corrects that estimate by one unit per clock until the estimate squared matches the operand exactly.

A one-cycle `start` pulse captures `number` and seeds the estimate with the operand divided by four. On every following clock the unit squares the estimate at double width and compares it with the captured operand. If the square is larger, the estimate drops by one. If it is smaller, the estimate rises by one. When the square is equal, `done` rises and the estimate is frozen on `sqrt_out` until the next `start`. Operands that are not perfect squares are outside the contract. For such operands the unit may never finish.

Top module: `sqrt_iter_unit`

## Requirements
- R1: A synchronous reset drives `sqrt_out` to 0 and `done` to 0, and with no `start` the result stays unchanged.
- R2: One clock after the edge that samples `start` high, `sqrt_out` equals `number` shifted right by two bits, and `done` is 0.
- R3: The estimate is squared at 16 bits and compared against the operand zero-extended to 16 bits. An estimate whose square exceeds 255 (for example 56 for operand 225) is therefore judged too large, and the search still converges.
- R4: While searching, each clock moves `sqrt_out` by exactly one. It moves down when the square is greater than the operand and up when the square is less.
- R5: `done` rises, with `sqrt_out` equal to the exact root, |root − (operand>>2)| + 1 clocks after the `start` edge.
- R6: Once `done` is 1, `sqrt_out` and `done` hold their values while `start` is low, whatever `number` does.
- R7: `start` takes priority over a search in progress and restarts it with the new operand.
- R8: An operand of 0 gives `done` = 1 and `sqrt_out` = 0 one clock after the `start` edge.
- R9: The operand is captured at `start`. Changes on `number` during a search do not alter the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Capture operand and seed the estimate |
| number | input | 8 | Operand, a perfect square |
| sqrt_out | output | 8 | Present estimate, which is the root once `done` is high |
| done | output | 1 | Square of the estimate equals the operand |

## Verification
The first estimate is due one clock after the `start` edge. After that, one unit step is due per clock. `done` is due exactly |root − operand/4| + 1 clocks after the `start` edge, so the bench works out that count for each operand from the requirements. The bench samples every output at the falling edge between two rising edges. It checks `done` low and a unit step on each intermediate cycle, and checks `done` high with the root on the predicted cycle. The hold, priority and operand-capture cases repeat this count after their own stimulus before they sample.

// File: rtl/sqrt_iter_pkg.sv
package sqrt_iter_pkg;

    // Direction chosen for the estimate on one clock
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_dir_e;

endpackage

// File: rtl/sqrt_square_cmp.sv
// Squares the estimate at double width and compares with the operand.
module sqrt_square_cmp #(
    parameter int W = 8
) (
    input  logic [W-1:0] guess,
    input  logic [W-1:0] operand,
    output logic         sq_gt,
    output logic         sq_eq
);
    localparam int WW = 2 * W;

    logic [WW-1:0] guess_ext;
    logic [WW-1:0] oper_ext;
    logic [WW-1:0] square;

    always_comb begin
        guess_ext = {{W{1'b0}}, guess};
        oper_ext  = {{W{1'b0}}, operand};
        square    = '0;
        // shift-and-add square, one partial product per estimate bit
        for (int b = 0; b < W; b++) begin
            if (guess[b]) begin
                square = square + (guess_ext << b);
            end
        end
        sq_gt = (square > oper_ext);
        sq_eq = (square == oper_ext);
    end

endmodule

// File: rtl/sqrt_step_sel.sv
// Turns the compare outcome into a step direction.
module sqrt_step_sel
    import sqrt_iter_pkg::*;
(
    input  logic      searching,
    input  logic      sq_gt,
    input  logic      sq_eq,
    output step_dir_e dir
);
    always_comb begin
        if (!searching || sq_eq) begin
            dir = STEP_HOLD;
        end else if (sq_gt) begin
            dir = STEP_DOWN;
        end else begin
            dir = STEP_UP;
        end
    end

endmodule

// File: rtl/sqrt_guess_next.sv
// Applies a unit step to the estimate.
module sqrt_guess_next
    import sqrt_iter_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] guess,
    input  step_dir_e    dir,
    output logic [W-1:0] guess_next
);
    localparam logic [W-1:0] ONE = W'(1);

    always_comb begin
        unique case (dir)
            STEP_UP:   guess_next = guess + ONE;
            STEP_DOWN: guess_next = guess - ONE;
            default:   guess_next = guess;
        endcase
    end

endmodule

// File: rtl/sqrt_iter_unit.sv
// Iterative integer square root: seed with operand/4, then unit steps.
module sqrt_iter_unit
    import sqrt_iter_pkg::*;
#(
    parameter int W     = 8,
    parameter int SEED_SHIFT = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] number,
    output logic [W-1:0] sqrt_out,
    output logic         done
);
    typedef struct packed {
        logic [W-1:0] guess;
        logic [W-1:0] operand;
        logic         busy;
        logic         fin;
    } state_t;

    state_t    st_q, st_d;
    logic      sq_gt, sq_eq;
    step_dir_e dir;
    logic [W-1:0] stepped;

    sqrt_square_cmp #(.W(W)) u_cmp (
        .guess   (st_q.guess),
        .operand (st_q.operand),
        .sq_gt   (sq_gt),
        .sq_eq   (sq_eq)
    );

    sqrt_step_sel u_sel (
        .searching (st_q.busy),
        .sq_gt     (sq_gt),
        .sq_eq     (sq_eq),
        .dir       (dir)
    );

    sqrt_guess_next #(.W(W)) u_next (
        .guess      (st_q.guess),
        .dir        (dir),
        .guess_next (stepped)
    );

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.guess   = number >> SEED_SHIFT;
            st_d.operand = number;
            st_d.busy    = 1'b1;
            st_d.fin     = 1'b0;
        end else if (st_q.busy) begin
            st_d.guess = stepped;
            if (sq_eq) begin
                st_d.busy = 1'b0;
                st_d.fin  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sqrt_out = st_q.guess;
    assign done     = st_q.fin;

    // seed after start
    p_seed_load_r2: assert property (@(posedge clk) disable iff (rst)
        start |=> (sqrt_out == ($past(number) >> SEED_SHIFT)) && !done);

    // unit step while searching
    p_unit_step_r4: assert property (@(posedge clk) disable iff (rst)
        (st_q.busy && !start) |=>
            ((sqrt_out - $past(sqrt_out)) == W'(1)) ||
            (($past(sqrt_out) - sqrt_out) == W'(1)) || done);

    // done only with an exact root
    p_exact_root_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> (({{W{1'b0}}, sqrt_out} * {{W{1'b0}}, sqrt_out}) ==
                  {{W{1'b0}}, st_q.operand}));

    // result frozen once done
    p_done_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done && $stable(sqrt_out));

    // idle without start is quiet
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (!st_q.busy && !start) |=> $stable(sqrt_out) && $stable(done));

endmodule

// File: tb/tb_sqrt_iter_unit.sv
`timescale 1ns/1ps
module tb_sqrt_iter_unit;

    logic       clk = 1'b0;
    logic       rst;
    logic       start;
    logic [7:0] number;
    logic [7:0] sqrt_out;
    logic       done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    sqrt_iter_unit dut (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .number   (number),
        .sqrt_out (sqrt_out),
        .done     (done)
    );

    // {operand, root, seed, cycles to done}
    localparam logic [31:0] VEC [16] = '{
        {8'd0,   8'd0,  8'd0,  8'd1},
        {8'd1,   8'd1,  8'd0,  8'd2},
        {8'd4,   8'd2,  8'd1,  8'd2},
        {8'd9,   8'd3,  8'd2,  8'd2},
        {8'd16,  8'd4,  8'd4,  8'd1},
        {8'd25,  8'd5,  8'd6,  8'd2},
        {8'd36,  8'd6,  8'd9,  8'd4},
        {8'd49,  8'd7,  8'd12, 8'd6},
        {8'd64,  8'd8,  8'd16, 8'd9},
        {8'd81,  8'd9,  8'd20, 8'd12},
        {8'd100, 8'd10, 8'd25, 8'd16},
        {8'd121, 8'd11, 8'd30, 8'd20},
        {8'd144, 8'd12, 8'd36, 8'd25},
        {8'd169, 8'd13, 8'd42, 8'd30},
        {8'd196, 8'd14, 8'd49, 8'd36},
        {8'd225, 8'd15, 8'd56, 8'd42}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_start(input logic [7:0] n);
        @(negedge clk);
        number = n;
        start  = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_vec(input logic [7:0] n, input logic [7:0] r,
                           input logic [7:0] g0, input logic [7:0] lat);
        logic [7:0] prev;
        logic [7:0] diff;
        pulse_start(n);
        chk("R2 seed", sqrt_out, g0);
        chk("R2 done low after start", {7'd0, done}, 8'd0);
        prev = sqrt_out;
        for (int k = 1; k <= int'(lat); k++) begin
            @(negedge clk);
            if (k < int'(lat)) begin
                chk("R5 done low mid-search", {7'd0, done}, 8'd0);
                diff = (sqrt_out > prev) ? sqrt_out - prev : prev - sqrt_out;
                chk("R4 unit step", diff, 8'd1);
                prev = sqrt_out;
            end else begin
                chk("R5 done on due cycle", {7'd0, done}, 8'd1);
                chk((32'(g0) * 32'(g0) > 255) ? "R3 wide compare root" : "R5 root",
                    sqrt_out, r);
            end
        end
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; number = 8'd0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R1 reset sqrt", sqrt_out, 8'd0);
        chk("R1 reset done", {7'd0, done}, 8'd0);
        repeat (3) @(negedge clk);
        chk("R1 idle sqrt", sqrt_out, 8'd0);

        for (int i = 0; i < 16; i++) begin
            run_vec(VEC[i][31:24], VEC[i][23:16], VEC[i][15:8], VEC[i][7:0]);
        end

        // R8 zero operand
        run_vec(8'd0, 8'd0, 8'd0, 8'd1);
        chk("R8 zero root", sqrt_out, 8'd0);

        // R6 hold after done while number wanders
        run_vec(8'd81, 8'd9, 8'd20, 8'd12);
        number = 8'd200;
        repeat (5) @(negedge clk);
        chk("R6 hold sqrt", sqrt_out, 8'd9);
        chk("R6 hold done", {7'd0, done}, 8'd1);

        // R9 operand captured at start
        pulse_start(8'd144);
        number = 8'd9;
        repeat (25) @(negedge clk);
        chk("R9 captured root", sqrt_out, 8'd12);
        chk("R9 done", {7'd0, done}, 8'd1);

        // R7 restart mid-search
        pulse_start(8'd225);
        repeat (3) @(negedge clk);
        pulse_start(8'd16);
        chk("R7 reseed", sqrt_out, 8'd4);
        @(negedge clk);
        chk("R7 done", {7'd0, done}, 8'd1);
        chk("R7 root", sqrt_out, 8'd4);

        // R1 reset mid-search
        pulse_start(8'd196);
        repeat (4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset mid sqrt", sqrt_out, 8'd0);
        chk("R1 reset mid done", {7'd0, done}, 8'd0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule